// File: doc/BRIEF.md
# Temperature Sensor Control Sequencer

This block sits between a simple request interface and an embedded analog temperature-sensing core. On an enable request it walks the core through a timed power-up order. First the power-down pin is held high for a minimum pulse. Then power-down and the core's active-low reset are both driven low, and the core is left to settle. Reset is then released, and after a short setup wait conversion is started. On a disable request it stops conversion while the core is still out of reset, and then powers the core down. Every wait is counted in clock cycles derived from the clock frequency parameter, rounded up so that each analog minimum is always met.

While the core is converting, the block keeps sampling the 12-bit raw code. It scales each sample to milli-degrees Celsius using a shift-subtract divider and presents the result as a signed registered value with a valid flag. A read port with valid/ready signalling exposes two words. One is the control and status word, which shows the three control pins and the raw code. The other is the converted temperature; it answers with a no-data flag whenever no valid conversion exists, in particular while the sensor is off.

Top module: `tsense_seq`

## Requirements
- R1: After reset, core power-down is 1, core reset (active low) is 0, run is 0, busy is 0 and the temperature valid flag is 0.
- R2: An enable request in the off state keeps power-down high for exactly ceil(1000 ns × f) cycles counted from the request edge, then drops power-down with core reset still low.
- R3: Core reset stays low for exactly ceil(50100 ns × f) cycles after power-down falls, then is released (driven to 1) while power-down stays 0.
- R4: Run rises exactly ceil(1000 ns × f) cycles after core reset is released, and run is never 1 while core reset is 0.
- R5: While running, the temperature output equals code × 237500 / 4094 − 81100 (truncating integer division), signed, with the valid flag set; a read of byte address 0x4 returns the same value with no-data 0.
- R6: A disable request while running clears run in the next cycle with core reset still released and power-down 0; one cycle later power-down is 1 and core reset is 0.
- R7: An enable request while running, or a disable request while off, is ignored: the pins do not change and busy stays 0.
- R8: A read of byte address 0x0 returns core reset at bit 0, power-down at bit 1, run at bit 2 and the raw code in bits 27:16, other bits 0; every request is accepted (ready is 1) and answered with response valid in the following cycle.
- R9: A read of byte address 0x4 while no valid conversion exists returns no-data 1 with data 0.
- R10: A disable request during any power-up step returns the block to the off state in the next cycle (power-down 1, core reset 0, busy 0); when enable and disable arrive together, disable wins.
- R11: The temperature valid flag is cleared within two cycles of a disable request and stays 0 while run is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req_i | input | 1 | Enable request (one-cycle pulse) |
| dis_req_i | input | 1 | Disable request (one-cycle pulse) |
| core_pd_o | output | 1 | Analog core power-down, 1 = powered down |
| core_rstn_o | output | 1 | Analog core reset, 0 = in reset |
| core_run_o | output | 1 | Analog core conversion enable |
| core_code_i | input | CODE_W | Raw conversion code from the core |
| busy_o | output | 1 | A power-up or stop sequence is in progress |
| temp_o | output | 32 | Signed temperature in milli-degrees Celsius |
| temp_valid_o | output | 1 | temp_o holds a finished conversion |
| rq_valid_i | input | 1 | Read request valid |
| rq_addr_i | input | ADDR_W | Read byte address (0x0 control/status, 0x4 temperature) |
| rq_ready_o | output | 1 | Read request accepted |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | 32 | Read response data |
| rsp_nodata_o | output | 1 | Temperature read found no valid conversion |

## Verification
The bench measures the exact cycle on which each pin changes during power-up. A counter that is off by one, or that truncates instead of rounding up, would move power-down fall, reset release or run rise by a cycle or more. It walks the raw code through zero, full scale, the divisor value and mid-range codes. A divider with a wrong bit count or a lost remainder bit would give a value off by the scale step, and a missing offset would read about 81 degrees high. It aborts power-up at each of its steps and sends both requests together. A design that let enable win, or that finished the sequence anyway, would leave power-down low or busy high. It also checks that stopping releases run before power-down, and that temperature reads after stopping report no data rather than a stale value.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int DATA_W    = 32;
    localparam int TEMP_W    = 32;

    // control/status word bit positions, decoded by software
    localparam int BIT_RSTN  = 0;
    localparam int BIT_PD    = 1;
    localparam int BIT_RUN   = 2;
    localparam int CODE_LSB  = 16;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PD_PULSE,
        ST_PWRUP,
        ST_SETTLE,
        ST_RUN,
        ST_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_DIV,
        CV_FIN
    } conv_phase_e;

    // cycles needed to cover a minimum time, rounded up
    function automatic int ns_to_cycles(input longint ns, input longint hz);
        longint prod;
        prod = ns * hz + 64'sd999_999_999;
        return int'(prod / 64'sd1_000_000_000);
    endfunction

endpackage

// File: rtl/tsense_fsm.sv
module tsense_fsm
    import tsense_pkg::*;
#(
    parameter longint CLK_FREQ_HZ = 125_000_000,
    parameter int     PD_PULSE_NS = 1000,
    parameter int     PWRUP_NS    = 50100,
    parameter int     SETTLE_NS   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req_i,
    input  logic dis_req_i,
    output logic pd_o,
    output logic core_rstn_o,
    output logic run_o,
    output logic busy_o
);

    localparam int T_PD   = ns_to_cycles(longint'(PD_PULSE_NS), CLK_FREQ_HZ);
    localparam int T_PU   = ns_to_cycles(longint'(PWRUP_NS), CLK_FREQ_HZ);
    localparam int T_SU   = ns_to_cycles(longint'(SETTLE_NS), CLK_FREQ_HZ);
    localparam int T_MAX0 = (T_PD > T_SU) ? T_PD : T_SU;
    localparam int T_MAX  = (T_PU > T_MAX0) ? T_PU : T_MAX0;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             pd;
        logic             rstn;
        logic             run;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.state)
            ST_OFF: begin
                if (en_req_i && !dis_req_i) begin
                    d.state = ST_PD_PULSE;
                    d.cnt   = CNT_W'(T_PD - 1);
                    d.pd    = 1'b1;
                    d.rstn  = 1'b0;
                    d.run   = 1'b0;
                end
            end
            ST_PD_PULSE, ST_PWRUP, ST_SETTLE: begin
                if (dis_req_i) begin
                    d.state = ST_OFF;
                    d.cnt   = '0;
                    d.pd    = 1'b1;
                    d.rstn  = 1'b0;
                    d.run   = 1'b0;
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else if (q.state == ST_PD_PULSE) begin
                    d.state = ST_PWRUP;
                    d.cnt   = CNT_W'(T_PU - 1);
                    d.pd    = 1'b0;
                    d.rstn  = 1'b0;
                end else if (q.state == ST_PWRUP) begin
                    d.state = ST_SETTLE;
                    d.cnt   = CNT_W'(T_SU - 1);
                    d.rstn  = 1'b1;
                end else begin
                    d.state = ST_RUN;
                    d.run   = 1'b1;
                end
            end
            ST_RUN: begin
                if (dis_req_i) begin
                    d.state = ST_STOP;
                    d.run   = 1'b0;
                end
            end
            ST_STOP: begin
                d.state = ST_OFF;
                d.pd    = 1'b1;
                d.rstn  = 1'b0;
            end
            default: begin
                d.state = ST_OFF;
                d.cnt   = '0;
                d.pd    = 1'b1;
                d.rstn  = 1'b0;
                d.run   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_OFF, cnt: '0, pd: 1'b1, rstn: 1'b0, run: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pd_o        = q.pd;
    assign core_rstn_o = q.rstn;
    assign run_o       = q.run;
    assign busy_o      = (q.state != ST_OFF) && (q.state != ST_RUN);

    // R4: conversion only with the core out of reset
    a_r4_run_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> q.rstn);

    // R2: power-down only falls while reset is still held
    a_r2_pd_fall_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pd) |-> (!q.rstn && !q.run));

    // R3: reset only released with the core powered
    a_r3_release_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rstn) |-> !q.pd);

    // R6: stopping keeps reset released, then powers down
    a_r6_stop_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.run) |-> (q.rstn && !q.pd) ##1 (q.pd && !q.rstn));

    // R10: disable in a power-up step lands in the off state
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req_i && busy_o && !q.run && q.state != ST_STOP) |=> (q.pd && !q.rstn && !busy_o));

endmodule

// File: rtl/tsense_conv.sv
module tsense_conv
    import tsense_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int SCALE_NUM = 237500,
    parameter int SCALE_DEN = 4094,
    parameter int OFFSET    = 81100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic signed [TEMP_W-1:0] temp_o,
    output logic                     valid_o
);

    localparam int NUM_W  = $clog2(SCALE_NUM + 1);
    localparam int PROD_W = CODE_W + NUM_W;
    localparam int DEN_W  = $clog2(SCALE_DEN + 1);
    localparam int REM_W  = DEN_W + 1;
    localparam int ITER_W = $clog2(PROD_W + 1);
    localparam int signed T_MIN = -OFFSET;

    typedef struct packed {
        conv_phase_e              phase;
        logic [PROD_W-1:0]        quo;
        logic [DEN_W-1:0]         rem;
        logic [ITER_W-1:0]        iter;
        logic signed [TEMP_W-1:0] temp;
        logic                     valid;
    } conv_t;

    conv_t q, d;
    logic [REM_W-1:0] rem_sh;

    always_comb begin
        d      = q;
        rem_sh = {q.rem, q.quo[PROD_W-1]};
        if (!run_i) begin
            d.phase = CV_IDLE;
            d.valid = 1'b0;
        end else begin
            case (q.phase)
                CV_IDLE: begin
                    d.quo   = PROD_W'(code_i) * PROD_W'(SCALE_NUM);
                    d.rem   = '0;
                    d.iter  = ITER_W'(PROD_W - 1);
                    d.phase = CV_DIV;
                end
                CV_DIV: begin
                    if (rem_sh >= REM_W'(SCALE_DEN)) begin
                        d.rem = DEN_W'(rem_sh - REM_W'(SCALE_DEN));
                        d.quo = {q.quo[PROD_W-2:0], 1'b1};
                    end else begin
                        d.rem = rem_sh[DEN_W-1:0];
                        d.quo = {q.quo[PROD_W-2:0], 1'b0};
                    end
                    if (q.iter == '0) begin
                        d.phase = CV_FIN;
                    end else begin
                        d.iter = q.iter - ITER_W'(1);
                    end
                end
                CV_FIN: begin
                    d.temp  = $signed(TEMP_W'(q.quo)) - $signed(TEMP_W'(OFFSET));
                    d.valid = 1'b1;
                    d.phase = CV_IDLE;
                end
                default: d.phase = CV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: CV_IDLE, quo: '0, rem: '0, iter: '0, temp: '0, valid: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign temp_o  = q.temp;
    assign valid_o = q.valid;

    // R11: no valid result once conversion is stopped
    a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !q.valid);

    // R5: a scaled result never lies below the offset floor
    a_r5_temp_floor: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> (q.temp >= T_MIN));

    // R5: the divider remainder stays below the divisor
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == CV_DIV) |-> (q.rem < DEN_W'(SCALE_DEN)));

endmodule

// File: rtl/tsense_regs.sv
module tsense_regs
    import tsense_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rq_valid_i,
    input  logic [ADDR_W-1:0]        rq_addr_i,
    output logic                     rq_ready_o,
    output logic                     rsp_valid_o,
    output logic [DATA_W-1:0]        rsp_data_o,
    output logic                     rsp_nodata_o,
    input  logic                     core_rstn_i,
    input  logic                     pd_i,
    input  logic                     run_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic                     temp_valid_i
);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_TEMP = ADDR_W'(4);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              nodata;
    } rsp_t;

    rsp_t q, d;

    always_comb begin
        d.valid  = rq_valid_i;
        d.data   = '0;
        d.nodata = 1'b0;
        if (rq_valid_i) begin
            if (rq_addr_i == ADDR_CTRL) begin
                d.data[BIT_RSTN]             = core_rstn_i;
                d.data[BIT_PD]               = pd_i;
                d.data[BIT_RUN]              = run_i;
                d.data[CODE_LSB +: CODE_W]   = code_i;
            end else if (rq_addr_i == ADDR_TEMP) begin
                if (temp_valid_i) begin
                    d.data = DATA_W'(temp_i);
                end else begin
                    d.nodata = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rq_ready_o   = 1'b1;
    assign rsp_valid_o  = q.valid;
    assign rsp_data_o   = q.data;
    assign rsp_nodata_o = q.nodata;

    // R9: a no-data answer carries no value
    a_r9_nodata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        q.nodata |-> (q.valid && q.data == '0));

    // R8: each response follows one accepted request
    a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid_i && rq_ready_o) |=> rsp_valid_o);

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
    import tsense_pkg::*;
#(
    parameter longint CLK_FREQ_HZ = 125_000_000,
    parameter int     CODE_W      = 12,
    parameter int     ADDR_W      = 4,
    parameter int     PD_PULSE_NS = 1000,
    parameter int     PWRUP_NS    = 50100,
    parameter int     SETTLE_NS   = 1000,
    parameter int     SCALE_NUM   = 237500,
    parameter int     SCALE_DEN   = 4094,
    parameter int     OFFSET      = 81100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_req_i,
    input  logic                     dis_req_i,
    output logic                     core_pd_o,
    output logic                     core_rstn_o,
    output logic                     core_run_o,
    input  logic [CODE_W-1:0]        core_code_i,
    output logic                     busy_o,
    output logic signed [TEMP_W-1:0] temp_o,
    output logic                     temp_valid_o,
    input  logic                     rq_valid_i,
    input  logic [ADDR_W-1:0]        rq_addr_i,
    output logic                     rq_ready_o,
    output logic                     rsp_valid_o,
    output logic [DATA_W-1:0]        rsp_data_o,
    output logic                     rsp_nodata_o
);

    tsense_fsm #(
        .CLK_FREQ_HZ (CLK_FREQ_HZ),
        .PD_PULSE_NS (PD_PULSE_NS),
        .PWRUP_NS    (PWRUP_NS),
        .SETTLE_NS   (SETTLE_NS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req_i    (en_req_i),
        .dis_req_i   (dis_req_i),
        .pd_o        (core_pd_o),
        .core_rstn_o (core_rstn_o),
        .run_o       (core_run_o),
        .busy_o      (busy_o)
    );

    tsense_conv #(
        .CODE_W    (CODE_W),
        .SCALE_NUM (SCALE_NUM),
        .SCALE_DEN (SCALE_DEN),
        .OFFSET    (OFFSET)
    ) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (core_run_o),
        .code_i  (core_code_i),
        .temp_o  (temp_o),
        .valid_o (temp_valid_o)
    );

    tsense_regs #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .rq_valid_i   (rq_valid_i),
        .rq_addr_i    (rq_addr_i),
        .rq_ready_o   (rq_ready_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_data_o   (rsp_data_o),
        .rsp_nodata_o (rsp_nodata_o),
        .core_rstn_i  (core_rstn_o),
        .pd_i         (core_pd_o),
        .run_i        (core_run_o),
        .code_i       (core_code_i),
        .temp_i       (temp_o),
        .temp_valid_i (temp_valid_o)
    );

endmodule

// File: tb/test_tsense_seq.sv
module test_tsense_seq;

    localparam int PERIOD_NS = 8;
    localparam int T1 = (1000 + PERIOD_NS - 1) / PERIOD_NS;
    localparam int T2 = (50100 + PERIOD_NS - 1) / PERIOD_NS;
    localparam int T3 = (1000 + PERIOD_NS - 1) / PERIOD_NS;
    localparam int NCODES = 8;
    localparam logic [11:0] CODES [NCODES] = '{12'd0, 12'd1, 12'd4094, 12'd4095,
                                               12'd1400, 12'd2047, 12'd345, 12'd3000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic        dis_req = 1'b0;
    logic        core_pd, core_rstn, core_run, busy;
    logic [11:0] core_code = 12'h000;
    logic signed [31:0] temp;
    logic        temp_valid;
    logic        rq_valid = 1'b0;
    logic [3:0]  rq_addr = 4'd0;
    logic        rq_ready, rsp_valid, rsp_nodata;
    logic [31:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tsense_seq i_tsense_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_req_i     (en_req),
        .dis_req_i    (dis_req),
        .core_pd_o    (core_pd),
        .core_rstn_o  (core_rstn),
        .core_run_o   (core_run),
        .core_code_i  (core_code),
        .busy_o       (busy),
        .temp_o       (temp),
        .temp_valid_o (temp_valid),
        .rq_valid_i   (rq_valid),
        .rq_addr_i    (rq_addr),
        .rq_ready_o   (rq_ready),
        .rsp_valid_o  (rsp_valid),
        .rsp_data_o   (rsp_data),
        .rsp_nodata_o (rsp_nodata)
    );

    function automatic longint exp_temp(input int code);
        return (longint'(code) * 237500) / 4094 - 81100;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic pulse(input bit en, input bit dis);
        en_req  = en;
        dis_req = dis;
        @(negedge clk);
        en_req  = 1'b0;
        dis_req = 1'b0;
    endtask

    task automatic rd(input logic [3:0] addr, output logic [31:0] data,
                      output logic nodata, output logic v, output logic rdy);
        rq_valid = 1'b1;
        rq_addr  = addr;
        rdy      = rq_ready;
        @(negedge clk);
        v        = rsp_valid;
        data     = rsp_data;
        nodata   = rsp_nodata;
        rq_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] data;
        logic nd, v, rdy;
        int i_pd, i_rs, i_run, bad_run;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 pd", core_pd, 1);
        chk("R1 rstn", core_rstn, 0);
        chk("R1 run", core_run, 0);
        chk("R1 busy", busy, 0);
        chk("R1 valid", temp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 temperature read while off
        rd(4'h4, data, nd, v, rdy);
        chk("R9 nodata", nd, 1);
        chk("R9 data", data, 0);
        // R8 control word while off
        core_code = 12'h123;
        rd(4'h0, data, nd, v, rdy);
        chk("R8 ready", rdy, 1);
        chk("R8 rsp valid", v, 1);
        chk("R8 ctrl off", data, 32'h0123_0002);

        // R7 disable while off ignored
        pulse(1'b0, 1'b1);
        chk("R7 pd off", core_pd, 1);
        chk("R7 busy off", busy, 0);

        // R10 both requests together: disable wins
        pulse(1'b1, 1'b1);
        chk("R10 both busy", busy, 0);
        chk("R10 both pd", core_pd, 1);
        // R10 abort in power-down pulse
        pulse(1'b1, 1'b0);
        chk("R10 seq busy", busy, 1);
        repeat (20) @(negedge clk);
        pulse(1'b0, 1'b1);
        chk("R10 abort1 busy", busy, 0);
        chk("R10 abort1 pd", core_pd, 1);
        // R10 abort in power-up wait
        pulse(1'b1, 1'b0);
        repeat (T1 + 50) @(negedge clk);
        chk("R10 in pwrup pd", core_pd, 0);
        pulse(1'b0, 1'b1);
        chk("R10 abort2 pd", core_pd, 1);
        chk("R10 abort2 rstn", core_rstn, 0);
        chk("R10 abort2 busy", busy, 0);
        // R10 abort in settle wait
        pulse(1'b1, 1'b0);
        repeat (T1 + T2 + 10) @(negedge clk);
        chk("R10 in settle rstn", core_rstn, 1);
        pulse(1'b0, 1'b1);
        chk("R10 abort3 pd", core_pd, 1);
        chk("R10 abort3 rstn", core_rstn, 0);
        chk("R10 abort3 run", core_run, 0);

        // R2 R3 R4 full power-up timing
        core_code = 12'd0;
        i_pd = -1; i_rs = -1; i_run = -1; bad_run = 0;
        pulse(1'b1, 1'b0);
        for (int idx = 1; idx <= T1 + T2 + T3 + 10; idx++) begin
            if (i_pd < 0 && !core_pd) i_pd = idx;
            if (i_rs < 0 && core_rstn) i_rs = idx;
            if (i_run < 0 && core_run) i_run = idx;
            if (core_run && !core_rstn) bad_run++;
            if (i_pd == idx && core_rstn) bad_run++;
            @(negedge clk);
        end
        chk("R2 pd fall cycle", i_pd, T1 + 1);
        chk("R3 release delay", i_rs - i_pd, T2);
        chk("R4 run delay", i_run - i_rs, T3);
        chk("R4 run without release", bad_run, 0);
        chk("R4 busy done", busy, 0);

        // R5 conversion table
        for (int k = 0; k < NCODES; k++) begin
            core_code = CODES[k];
            repeat (100) @(negedge clk);
            chk("R5 valid", temp_valid, 1);
            chk("R5 temp", temp, exp_temp(int'(CODES[k])));
            rd(4'h4, data, nd, v, rdy);
            chk("R5 read nodata", nd, 0);
            chk("R5 read temp", $signed(data), exp_temp(int'(CODES[k])));
        end

        // R8 control word while running
        core_code = 12'hABC;
        rd(4'h0, data, nd, v, rdy);
        chk("R8 ctrl run", data, 32'h0ABC_0005);

        // R7 enable while running ignored
        pulse(1'b1, 1'b0);
        chk("R7 run kept", core_run, 1);
        chk("R7 busy run", busy, 0);
        chk("R7 valid kept", temp_valid, 1);

        // R6 stop order, R11 valid drop
        pulse(1'b0, 1'b1);
        chk("R6 run cleared", core_run, 0);
        chk("R6 rstn held", core_rstn, 1);
        chk("R6 pd still low", core_pd, 0);
        @(negedge clk);
        chk("R6 pd high", core_pd, 1);
        chk("R6 rstn low", core_rstn, 0);
        chk("R11 valid low", temp_valid, 0);
        repeat (50) @(negedge clk);
        chk("R11 valid stays low", temp_valid, 0);
        rd(4'h4, data, nd, v, rdy);
        chk("R9 nodata after stop", nd, 1);

        finish_up();
    end

endmodule